// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block is the control register at management address 0 of an Ethernet PHY. An MDIO front end, which lies outside this block, turns serial management frames into single-cycle read and write strobes. This block answers those strobes. It merges software writes with state that comes from pins and from other logic. It also works out the reset value of each field from strap pins. Its outputs drive the rest of the PHY:

- the manual speed and duplex selection;
- the auto-negotiation enable and restart;
- power-down;
- loopback;
- a soft-reset request;
- an isolate control, which turns off the MII output drivers and blocks the MII transmit inputs.

A soft reset stays pending until the reset and recalibration logic returns a done strobe. The reset bit also reads as 1 while a recalibration for a mode change is running. A pin can force loopback on and off. An external compatibility-mode bit locks out the power-down field.

Top module: `phy_ctrl_reg`

## Requirements
- R1: Writing address 0 with bit 15 set reloads every field from its strap default, using the straps sampled in that cycle. soft_reset_req goes high after that clock edge. It stays high, and bit 15 reads 1, until reset_done is sampled high. It clears at that edge. Writes that arrive while the reset is pending are ignored.
- R2: Bit 15 reads 1 in every cycle in which recal_busy is high, even with no soft reset pending.
- R3: A rising edge on lpbk_pin sets bit 14 and the loopback output at the next clock edge. A falling edge clears them at the next clock edge. The pin edge wins over a write in the same cycle. With no pin edge, bit 14 is read/write. After a soft reset, bit 14 takes the level of the pin.
- R4: Bit 13 selects the speed (1 = 100 Mb/s) and bit 8 selects full duplex. The outputs cfg_speed_100 and cfg_full_duplex follow these bits only while bit 12 (auto-negotiation enable, driven on an_enable) is 0. While bit 12 is 1, both outputs are 0.
- R5: Bits 13 and 12 reset to 1 when strap_an equals 2'b11, and to 0 for any other strap_an value.
- R6: Bit 11 is power-down. While compat_mode is high, the power_down output is 0, bit 11 reads 0, and writes leave the stored bit 11 unchanged. The stored value shows again once compat_mode falls.
- R7: Bit 10 (isolate) resets to 1 when strap_phy_addr is 0, and otherwise to the level of strap_iso_dflt.
- R8: While isolate is 1, mii_out_oe is 0 and core_tx_en, core_tx_er and core_txd are 0. Otherwise mii_out_oe is 1 and the three transmit signals copy mii_tx_en, mii_tx_er and mii_txd.
- R9: Writing bit 9 as 1 raises an_restart for exactly one cycle after the write edge. Bit 9 reads 1 only in that cycle and reads 0 from then on.
- R10: Bit 8 (duplex) and bit 7 (collision test) are read/write. Bits 6 to 0 read 0 and ignore writes. All bits reset to 0 except bits 15 to 10, whose reset values are set by R1, R3, R5 and R7.
- R11: reg_rdata shows the register in the same cycle when reg_rd_en is high and reg_addr is 0. It is 0 otherwise. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_wr_en | input | 1 | Write strobe from the management front end |
| reg_rd_en | input | 1 | Read strobe from the management front end |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational |
| strap_an | input | 2 | Auto-negotiation strap pins |
| strap_phy_addr | input | 5 | PHY address strap pins |
| strap_iso_dflt | input | 1 | Isolate default strap |
| lpbk_pin | input | 1 | Loopback control pin |
| compat_mode | input | 1 | Compatibility-mode bit that locks power-down |
| recal_busy | input | 1 | A mode-change recalibration is running |
| reset_done | input | 1 | Reset and recalibration have completed |
| soft_reset_req | output | 1 | Soft reset pending |
| cfg_speed_100 | output | 1 | Manual 100 Mb/s selection |
| cfg_full_duplex | output | 1 | Manual full-duplex selection |
| an_enable | output | 1 | Auto-negotiation enabled |
| an_restart | output | 1 | One-cycle auto-negotiation restart pulse |
| power_down | output | 1 | Power-down control |
| loopback | output | 1 | Loopback control |
| isolate | output | 1 | Isolate control |
| mii_out_oe | output | 1 | Output enable for the MII output drivers |
| mii_tx_en | input | 1 | MII transmit enable from the MAC |
| mii_tx_er | input | 1 | MII transmit error from the MAC |
| mii_txd | input | 4 | MII transmit data from the MAC |
| core_tx_en | output | 1 | Gated transmit enable to the PHY core |
| core_tx_er | output | 1 | Gated transmit error to the PHY core |
| core_txd | output | 4 | Gated transmit data to the PHY core |

## Verification
Results arrive on two kinds of timing.

- Combinational results are due in the same cycle as their stimulus. These are read data (including the effect of recal_busy on bit 15), the power-down lockout while compat_mode is high, and the isolate gating. The bench drives inputs on the falling edge and samples these results 1 ns later, before the next rising edge.
- Registered results are due one rising edge after their stimulus. These are writes, the pin edges on loopback, the restart pulse and the clearing of soft_reset_req by reset_done. The bench checks them at the falling edge that follows that rising edge, and checks the restart pulse again one cycle later to confirm it has dropped.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;

    localparam int REG_W   = 16;
    localparam int B_RESET = 15;
    localparam int B_LOOP  = 14;
    localparam int B_SPEED = 13;
    localparam int B_ANEN  = 12;
    localparam int B_PDN   = 11;
    localparam int B_ISO   = 10;
    localparam int B_ANRST = 9;
    localparam int B_DUP   = 8;
    localparam int B_COL   = 7;

    typedef struct packed {
        logic rst_pend;
        logic loop_en;
        logic spd_100;
        logic an_en;
        logic pwr_dn;
        logic iso;
        logic an_rst;
        logic full_dup;
        logic col_test;
        logic lpbk_seen;
    } ctrl_state_t;

endpackage

// File: rtl/phy_ctrl_defaults.sv
module phy_ctrl_defaults
    import phy_ctrl_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [1:0]        strap_an,
    input  logic [ADDR_W-1:0] strap_phy_addr,
    input  logic              strap_iso_dflt,
    input  logic              lpbk_pin,
    output ctrl_state_t       dflt
);

    logic an_on;
    logic iso_on;

    always_comb begin
        an_on  = (strap_an == 2'b11);
        iso_on = (strap_phy_addr == '0) ? 1'b1 : strap_iso_dflt;

        dflt           = '0;
        dflt.loop_en   = lpbk_pin;
        dflt.lpbk_seen = lpbk_pin;
        dflt.spd_100   = an_on;
        dflt.an_en     = an_on;
        dflt.iso       = iso_on;
    end

endmodule

// File: rtl/phy_ctrl_mii_gate.sv
module phy_ctrl_mii_gate #(
    parameter int TXD_W = 4
) (
    input  logic             iso,
    input  logic             tx_en_in,
    input  logic             tx_er_in,
    input  logic [TXD_W-1:0] txd_in,
    output logic             out_oe,
    output logic             tx_en_out,
    output logic             tx_er_out,
    output logic [TXD_W-1:0] txd_out
);

    assign out_oe    = ~iso;
    assign tx_en_out = tx_en_in & ~iso;
    assign tx_er_out = tx_er_in & ~iso;

    for (genvar g = 0; g < TXD_W; g++) begin : g_txd
        assign txd_out[g] = txd_in[g] & ~iso;
    end

endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
    import phy_ctrl_pkg::*;
#(
    parameter int          ADDR_W   = 5,
    parameter int          TXD_W    = 4,
    parameter logic [4:0]  REG_ADDR = 5'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [1:0]        strap_an,
    input  logic [ADDR_W-1:0] strap_phy_addr,
    input  logic              strap_iso_dflt,
    input  logic              lpbk_pin,
    input  logic              compat_mode,
    input  logic              recal_busy,
    input  logic              reset_done,
    output logic              soft_reset_req,
    output logic              cfg_speed_100,
    output logic              cfg_full_duplex,
    output logic              an_enable,
    output logic              an_restart,
    output logic              power_down,
    output logic              loopback,
    output logic              isolate,
    output logic              mii_out_oe,
    input  logic              mii_tx_en,
    input  logic              mii_tx_er,
    input  logic [TXD_W-1:0]  mii_txd,
    output logic              core_tx_en,
    output logic              core_tx_er,
    output logic [TXD_W-1:0]  core_txd
);

    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

    ctrl_state_t s_d, s_q, dflt;
    logic        hit_wr, hit_rd;
    logic [REG_W-1:0] view;

    phy_ctrl_defaults #(.ADDR_W(ADDR_W)) u_dflt (
        .strap_an       (strap_an),
        .strap_phy_addr (strap_phy_addr),
        .strap_iso_dflt (strap_iso_dflt),
        .lpbk_pin       (lpbk_pin),
        .dflt           (dflt)
    );

    phy_ctrl_mii_gate #(.TXD_W(TXD_W)) u_gate (
        .iso       (s_q.iso),
        .tx_en_in  (mii_tx_en),
        .tx_er_in  (mii_tx_er),
        .txd_in    (mii_txd),
        .out_oe    (mii_out_oe),
        .tx_en_out (core_tx_en),
        .tx_er_out (core_tx_er),
        .txd_out   (core_txd)
    );

    always_comb begin
        hit_wr = reg_wr_en && (reg_addr == MY_ADDR);
        hit_rd = reg_rd_en && (reg_addr == MY_ADDR);

        s_d           = s_q;
        s_d.an_rst    = 1'b0;
        s_d.lpbk_seen = lpbk_pin;

        if (s_q.rst_pend) begin
            if (reset_done) begin
                s_d.rst_pend = 1'b0;
            end
        end else if (hit_wr) begin
            if (reg_wdata[B_RESET]) begin
                s_d          = dflt;
                s_d.rst_pend = 1'b1;
            end else begin
                s_d.loop_en  = reg_wdata[B_LOOP];
                s_d.spd_100  = reg_wdata[B_SPEED];
                s_d.an_en    = reg_wdata[B_ANEN];
                s_d.iso      = reg_wdata[B_ISO];
                s_d.an_rst   = reg_wdata[B_ANRST];
                s_d.full_dup = reg_wdata[B_DUP];
                s_d.col_test = reg_wdata[B_COL];
                if (!compat_mode) begin
                    s_d.pwr_dn = reg_wdata[B_PDN];
                end
            end
        end

        if (lpbk_pin && !s_q.lpbk_seen) begin
            s_d.loop_en = 1'b1;
        end else if (!lpbk_pin && s_q.lpbk_seen) begin
            s_d.loop_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= dflt;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        view          = '0;
        view[B_RESET] = s_q.rst_pend | recal_busy;
        view[B_LOOP]  = s_q.loop_en;
        view[B_SPEED] = s_q.spd_100;
        view[B_ANEN]  = s_q.an_en;
        view[B_PDN]   = s_q.pwr_dn & ~compat_mode;
        view[B_ISO]   = s_q.iso;
        view[B_ANRST] = s_q.an_rst;
        view[B_DUP]   = s_q.full_dup;
        view[B_COL]   = s_q.col_test;
        reg_rdata     = hit_rd ? view : '0;
    end

    assign soft_reset_req  = s_q.rst_pend;
    assign cfg_speed_100   = s_q.spd_100 & ~s_q.an_en;
    assign cfg_full_duplex = s_q.full_dup & ~s_q.an_en;
    assign an_enable       = s_q.an_en;
    assign an_restart      = s_q.an_rst;
    assign power_down      = s_q.pwr_dn & ~compat_mode;
    assign loopback        = s_q.loop_en;
    assign isolate         = s_q.iso;

    AST_RESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_req && !reset_done |=> soft_reset_req); // R1
    AST_RESET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_req && reset_done |=> !soft_reset_req); // R1
    AST_LOOP_PIN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        lpbk_pin && !s_q.lpbk_seen |=> loopback); // R3
    AST_LOOP_PIN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !lpbk_pin && s_q.lpbk_seen |=> !loopback); // R3
    AST_PDN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        compat_mode && hit_wr && !soft_reset_req && !reg_wdata[B_RESET]
        |=> $stable(s_q.pwr_dn)); // R6
    AST_RESTART_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart && !(hit_wr && reg_wdata[B_ANRST]) |=> !an_restart); // R9
    AST_ISO_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        isolate |-> !core_tx_en && !core_tx_er && !mii_out_oe); // R8

endmodule

// File: tb/phy_ctrl_reg_tb.sv
module phy_ctrl_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [1:0]  strap_an = 2'b00;
    logic [4:0]  strap_phy_addr = 5'd5;
    logic        strap_iso_dflt = 1'b0;
    logic        lpbk_pin = 1'b0, compat_mode = 1'b0;
    logic        recal_busy = 1'b0, reset_done = 1'b0;
    logic        soft_reset_req, cfg_speed_100, cfg_full_duplex, an_enable;
    logic        an_restart, power_down, loopback, isolate, mii_out_oe;
    logic        mii_tx_en = 1'b0, mii_tx_er = 1'b0;
    logic [3:0]  mii_txd = '0;
    logic        core_tx_en, core_tx_er;
    logic [3:0]  core_txd;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    phy_ctrl_reg dut_i (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_addr = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        reg_rd_en = 1'b0; reg_addr = '0;
    endtask

    // expected register view from model fields
    function automatic logic [15:0] view(input logic pend, lb, spd, an, pd, iso, dup, col, cm);
        logic [15:0] v;
        v = '0;
        v[15] = pend; v[14] = lb; v[13] = spd; v[12] = an;
        v[11] = pd & ~cm; v[10] = iso; v[8] = dup; v[7] = col;
        return v;
    endfunction

    initial begin
        logic [15:0] v;
        logic m_lb, m_spd, m_an, m_pd, m_iso, m_dup, m_col;
        void'($urandom(32'h5eed_1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 R7 R10: hardware reset with strap_an=00, address 5, iso default 0
        rd(5'd0, v);  check("R5 R7 R10 reset value", v, 16'h0000);
        check("R8 oe after reset", {15'd0, mii_out_oe}, 16'd1);

        // R2: recal_busy shows on bit 15
        recal_busy = 1'b1; rd(5'd0, v); check("R2 recal busy", v, 16'h8000);
        recal_busy = 1'b0;

        // R11: read of other address or without strobe gives 0
        reg_addr = 5'd0; #1 check("R11 no strobe", reg_rdata, 16'h0000);
        wr(5'd3, 16'h2180);
        rd(5'd0, v); check("R11 other address write ignored", v, 16'h0000);

        // R1 R5 R7: soft reset with AN straps on and address 0
        strap_an = 2'b11; strap_phy_addr = 5'd0;
        wr(5'd0, 16'h8000);
        rd(5'd0, v); check("R1 R5 R7 soft reset pending", v, 16'hB400);
        check("R1 soft_reset_req", {15'd0, soft_reset_req}, 16'd1);
        check("R4 AN masks speed", {14'd0, cfg_speed_100, cfg_full_duplex}, 16'd0);
        wr(5'd0, 16'h0100);
        rd(5'd0, v); check("R1 write ignored while pending", v, 16'hB400);
        repeat (3) @(negedge clk);
        check("R1 held without done", {15'd0, soft_reset_req}, 16'd1);
        reset_done = 1'b1; @(negedge clk); reset_done = 1'b0;
        rd(5'd0, v); check("R1 cleared by done", v, 16'h3400);

        // R5 R7: other strap combination, isolate from pin
        strap_an = 2'b01; strap_phy_addr = 5'd3; strap_iso_dflt = 1'b1;
        wr(5'd0, 16'h8000);
        reset_done = 1'b1; @(negedge clk); reset_done = 1'b0;
        rd(5'd0, v); check("R5 R7 strap variant", v, 16'h0400);

        // R8: isolate gates transmit inputs
        mii_tx_en = 1'b1; mii_tx_er = 1'b1; mii_txd = 4'hA; #1;
        check("R8 isolated tx", {10'd0, mii_out_oe, core_tx_en, core_tx_er, core_txd}, 16'h0000);

        // R9: restart pulse one cycle
        wr(5'd0, 16'h0200);
        check("R9 restart high", {15'd0, an_restart}, 16'd1);
        @(negedge clk);
        check("R9 restart low", {15'd0, an_restart}, 16'd0);
        rd(5'd0, v); check("R9 bit reads 0", v, 16'h0000);

        // R3: pin edges drive loopback
        lpbk_pin = 1'b1; @(negedge clk);
        check("R3 pin rise", {15'd0, loopback}, 16'd1);
        wr(5'd0, 16'h0000);
        rd(5'd0, v); check("R3 write clears without edge", v, 16'h0000);
        wr(5'd0, 16'h4000);
        @(negedge clk); reg_wr_en = 1'b1; reg_wdata = 16'h4000; lpbk_pin = 1'b0;
        @(negedge clk); reg_wr_en = 1'b0;
        check("R3 fall wins over write", {15'd0, loopback}, 16'd0);

        // R6: compat locks power-down
        wr(5'd0, 16'h0800);
        check("R6 pd set", {15'd0, power_down}, 16'd1);
        compat_mode = 1'b1; #1;
        check("R6 pd forced off", {15'd0, power_down}, 16'd0);
        wr(5'd0, 16'h0000);
        compat_mode = 1'b0; #1;
        rd(5'd0, v); check("R6 stored pd kept", v, 16'h0800);

        // random phase
        m_lb = 0; m_spd = 0; m_an = 0; m_pd = 1; m_iso = 0; m_dup = 0; m_col = 0;
        for (int i = 0; i < 300; i++) begin
            logic [15:0] d;
            d = 16'($urandom) & ~16'h8200;
            compat_mode = ($urandom % 4) == 0;
            wr(5'd0, d);
            m_lb = d[14]; m_spd = d[13]; m_an = d[12]; m_iso = d[10];
            m_dup = d[8]; m_col = d[7];
            if (!compat_mode) m_pd = d[11];
            mii_tx_en = 1'($urandom); mii_tx_er = 1'($urandom); mii_txd = 4'($urandom);
            rd(5'd0, v);
            check("R10 R11 R6 random read", v, view(1'b0, m_lb, m_spd, m_an, m_pd, m_iso, m_dup, m_col, compat_mode));
            check("R4 R6 R3 outputs", {11'd0, cfg_speed_100, cfg_full_duplex, power_down, loopback, isolate},
                  {11'd0, m_spd & ~m_an, m_dup & ~m_an, m_pd & ~compat_mode, m_lb, m_iso});
            check("R8 gating", {10'd0, mii_out_oe, core_tx_en, core_tx_er, core_txd},
                  m_iso ? 16'h0000 : {10'd0, 1'b1, mii_tx_en, mii_tx_er, mii_txd});
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule